// File: doc/BRIEF.md
# Control Register with Clock-Domain Handshake

This block holds the main 32-bit control word of a serial-bus controller and serves it over an APB-style bus in the bus clock domain. Most fields are plain configuration: time-out enables and selects, speed, stretch mode, SDA hold, pin usage, standby behaviour and the operating mode. These fields are held static while the peripheral runs, so that the core logic can sample them at any time.

Two bits act in the asynchronous core clock domain: the enable bit and the software-reset bit. Each one crosses through its own toggle request and toggle acknowledge. The core side shows a level request and waits for a one-cycle "done" pulse from the core logic. The bus side shows a busy flag until that acknowledge has come back. A software reset takes priority over everything else in the same write. While it is outstanding, every write is refused with an error and the control word reads as its reset value.

Top module: `ctrl_reg_sync`

## Requirements
- R1: After reset the control word (offset 0x0), the busy word (offset 0x4), `cfg_o`, `master_mode_o`, `core_en`, `core_en_req` and `core_srst_req` are all zero.
- R2: The writable control bits are 30, 29:28, 27, 25:24, 23, 22, 21:20, 16, 7, 4:2, 1 and 0. Every other bit reads 0 and ignores writes, so writing 0xFFFFFFFC to a disabled block reads back 0x7BF1009C and starts no reset.
- R3: A control write with bit 0 set discards every other bit of that write: enable and the fields keep their old values, and `cfg_o` shows only bit 0 newly set.
- R4: A reset request reaches the core as `core_srst_req` and holds until `core_srst_done` pulses. Bit 0 of `cfg_o` and busy bit 0 stay 1 until the acknowledge returns. Then they clear together with all fields and enable, and `core_en` is 0.
- R5: While a reset is outstanding, every write, to any offset, gets `pslverr`=1 and changes nothing.
- R6: While a reset is outstanding, reads of the control word return 0. The busy word still shows bit 0 = reset busy and bit 1 = enable busy.
- R7: A write that changes bit 1 reads back the new value at once and sets busy bit 1. `core_en_req` rises in the core domain and `core_en` takes the new value. Busy bit 1 clears only after `core_en_done` pulses.
- R8: While bit 1 reads 1, writes to every field other than bits 1 and 0 are ignored. While busy bit 1 is set, a write that tries to change bit 1 leaves it unchanged.
- R9: While `wprot` is high, writes return `pslverr`=1 and leave the register unchanged. Reads are unaffected.
- R10: `master_mode_o` is 1 exactly when bits 4:2 hold 3'b101.
- R11: `pready` is always 1. Reads of any offset other than 0x0 and 0x4 return 0, and writes to them have no effect and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus-domain clock |
| brst | input | 1 | Bus-domain synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error response |
| wprot | input | 1 | External write protect |
| cfg_o | output | 32 | Stored control word, with bit 0 showing a reset in progress |
| master_mode_o | output | 1 | Mode field selects master operation |
| cclk | input | 1 | Core-domain clock |
| crst | input | 1 | Core-domain synchronous reset, active high |
| core_srst_req | output | 1 | Reset request to the core logic (core domain) |
| core_srst_done | input | 1 | One-cycle pulse: core reset finished |
| core_en | output | 1 | Enable level in the core domain |
| core_en_req | output | 1 | Enable change waiting for confirmation |
| core_en_done | input | 1 | One-cycle pulse: enable change confirmed |

## Verification
A lost or doubled toggle on either crossing leaves a busy bit stuck at 1, or clears it early. Either fault shows on the next read of the busy word and as a missing or extra `core_*_req` level within a few core cycles. A wrong protection or discard decision corrupts the control word, and this is visible on `cfg_o` in the cycle after the write. A stale reset flag turns the next write into an error response. A read during the reset window returns nonzero data at once if the reset-value masking is missing.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  localparam int DW = 32;

  localparam int B_SWRST     = 0;
  localparam int B_EN        = 1;
  localparam int MODE_LSB    = 2;
  localparam int MODE_W      = 3;
  localparam int B_STBY      = 7;
  localparam int B_PINS      = 16;
  localparam int HOLD_LSB    = 20;
  localparam int HOLD_W      = 2;
  localparam int B_MEXT      = 22;
  localparam int B_SEXT      = 23;
  localparam int SPD_LSB     = 24;
  localparam int SPD_W       = 2;
  localparam int B_STRETCH   = 27;
  localparam int INACT_LSB   = 28;
  localparam int INACT_W     = 2;
  localparam int B_LOWTO     = 30;

  localparam logic [MODE_W-1:0] MODE_MASTER = 3'd5;

  function automatic logic [DW-1:0] fmask(input int lsb, input int w);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] PROT_MASK =
      fmask(MODE_LSB, MODE_W) | fmask(B_STBY, 1) | fmask(B_PINS, 1) |
      fmask(HOLD_LSB, HOLD_W) | fmask(B_MEXT, 1) | fmask(B_SEXT, 1) |
      fmask(SPD_LSB, SPD_W) | fmask(B_STRETCH, 1) |
      fmask(INACT_LSB, INACT_W) | fmask(B_LOWTO, 1);

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_BUSY} reg_sel_e;
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_src.sv
module hs_src #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack_tgl_a,
  output logic req_tgl,
  output logic busy,
  output logic done
);
  logic ack_s, ack_q;

  sync_2ff #(.STAGES(STAGES)) i_ack_sync (
    .clk(clk), .rst(rst), .d_async(ack_tgl_a), .q(ack_s)
  );

  assign done = ack_s ^ ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl <= 1'b0;
      ack_q   <= 1'b0;
      busy    <= 1'b0;
    end else begin
      ack_q <= ack_s;
      if (start && !busy) begin
        req_tgl <= ~req_tgl;
        busy    <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  // R7: a new request toggle is only launched from the idle state
  a_r7_req_from_idle: assert property (@(posedge clk) disable iff (rst)
    (req_tgl != $past(req_tgl)) |-> !$past(busy));

  // R4: busy never drops without a returned acknowledge
  a_r4_busy_until_ack: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !busy) |-> $past(done));
endmodule

// File: rtl/hs_dst.sv
module hs_dst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_tgl_a,
  input  logic finish,
  output logic ack_tgl,
  output logic pending,
  output logic arrive
);
  logic req_s, req_q;

  sync_2ff #(.STAGES(STAGES)) i_req_sync (
    .clk(clk), .rst(rst), .d_async(req_tgl_a), .q(req_s)
  );

  assign arrive = req_s ^ req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      pending <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      req_q <= req_s;
      if (arrive) begin
        pending <= 1'b1;
      end else if (finish && pending) begin
        pending <= 1'b0;
        ack_tgl <= ~ack_tgl;
      end
    end
  end

  // R4: an acknowledge toggle is only returned for a pending request
  a_r4_ack_needs_pending: assert property (@(posedge clk) disable iff (rst)
    (ack_tgl != $past(ack_tgl)) |-> $past(pending));
endmodule

// File: rtl/ctrl_reg_sync.sv
module ctrl_reg_sync
  import ctrl_reg_pkg::*;
#(
  parameter int AW          = 8,
  parameter int CTRL_OFS    = 0,
  parameter int BUSY_OFS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          bclk,
  input  logic          brst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic          wprot,
  output logic [DW-1:0] cfg_o,
  output logic          master_mode_o,
  input  logic          cclk,
  input  logic          crst,
  output logic          core_srst_req,
  input  logic          core_srst_done,
  output logic          core_en,
  output logic          core_en_req,
  input  logic          core_en_done
);
  localparam int BUSY_W = 2;

  logic [DW-1:0] ctrl_q;
  reg_sel_e      sel;
  logic          setup_ph, access_ph, wr_ok;
  logic          rst_start, en_take;
  logic          rst_busy, rst_done, rst_req_t, rst_ack_t;
  logic          en_busy, en_done, en_req_t, en_ack_t;
  logic          rst_arrive, en_arrive;
  logic [DW-1:0] rd_val;

  assign pready    = 1'b1;
  assign setup_ph  = psel && !penable;
  assign access_ph = psel && penable;

  always_comb begin
    if (paddr == AW'(CTRL_OFS))      sel = SEL_CTRL;
    else if (paddr == AW'(BUSY_OFS)) sel = SEL_BUSY;
    else                             sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_val = rst_busy ? '0 : ctrl_q;
      SEL_BUSY: rd_val = DW'({en_busy, rst_busy});
      default:  rd_val = '0;
    endcase
  end

  assign wr_ok     = access_ph && pwrite && !pslverr && (sel == SEL_CTRL);
  assign rst_start = wr_ok && pwdata[B_SWRST];
  assign en_take   = wr_ok && !pwdata[B_SWRST] && !en_busy &&
                     (pwdata[B_EN] != ctrl_q[B_EN]);

  always_ff @(posedge bclk) begin
    if (brst) begin
      prdata        <= '0;
      pslverr       <= 1'b0;
      ctrl_q        <= '0;
      master_mode_o <= 1'b0;
    end else begin
      if (setup_ph) begin
        pslverr <= pwrite && (rst_busy || wprot);
        prdata  <= pwrite ? '0 : rd_val;
      end
      if (rst_done) begin
        ctrl_q <= '0;
      end else if (wr_ok && !pwdata[B_SWRST]) begin
        if (!ctrl_q[B_EN])
          ctrl_q <= (ctrl_q & ~PROT_MASK) | (pwdata & PROT_MASK);
        if (en_take)
          ctrl_q[B_EN] <= pwdata[B_EN];
      end
      master_mode_o <= (ctrl_q[MODE_LSB +: MODE_W] == MODE_MASTER);
    end
  end

  assign cfg_o = ctrl_q | DW'(rst_busy);

  hs_src #(.STAGES(SYNC_STAGES)) i_rst_src (
    .clk(bclk), .rst(brst), .start(rst_start), .ack_tgl_a(rst_ack_t),
    .req_tgl(rst_req_t), .busy(rst_busy), .done(rst_done)
  );

  hs_src #(.STAGES(SYNC_STAGES)) i_en_src (
    .clk(bclk), .rst(brst), .start(en_take), .ack_tgl_a(en_ack_t),
    .req_tgl(en_req_t), .busy(en_busy), .done(en_done)
  );

  hs_dst #(.STAGES(SYNC_STAGES)) i_rst_dst (
    .clk(cclk), .rst(crst), .req_tgl_a(rst_req_t), .finish(core_srst_done),
    .ack_tgl(rst_ack_t), .pending(core_srst_req), .arrive(rst_arrive)
  );

  hs_dst #(.STAGES(SYNC_STAGES)) i_en_dst (
    .clk(cclk), .rst(crst), .req_tgl_a(en_req_t), .finish(core_en_done),
    .ack_tgl(en_ack_t), .pending(core_en_req), .arrive(en_arrive)
  );

  // Enable level is held stable by the bus side while its request is in flight.
  always_ff @(posedge cclk) begin
    if (crst)            core_en <= 1'b0;
    else if (rst_arrive) core_en <= 1'b0;
    else if (en_arrive)  core_en <= core_srst_req ? 1'b0 : ctrl_q[B_EN];
  end

  // R5: any write presented during a reset is answered with an error
  a_r5_err_in_reset: assert property (@(posedge bclk) disable iff (brst)
    (access_ph && pwrite && $past(setup_ph) && $past(rst_busy)) |-> pslverr);

  // R6: the control word reads as zero during a reset
  a_r6_read_zero: assert property (@(posedge bclk) disable iff (brst)
    (access_ph && !pwrite && sel == SEL_CTRL && $past(setup_ph) && $past(rst_busy))
      |-> (prdata == '0));

  // R8: protected fields hold while enabled, except at reset completion
  a_r8_protected_hold: assert property (@(posedge bclk) disable iff (brst)
    ($past(ctrl_q[B_EN]) && !$past(rst_done))
      |-> ((ctrl_q & PROT_MASK) == ($past(ctrl_q) & PROT_MASK)));

  // R3: the write that starts a reset leaves the stored word untouched
  a_r3_discard_rest: assert property (@(posedge bclk) disable iff (brst)
    $rose(rst_busy) |-> (ctrl_q == $past(ctrl_q)));

  // R9: write protection forces an error response
  a_r9_wprot_err: assert property (@(posedge bclk) disable iff (brst)
    (access_ph && pwrite && $past(setup_ph) && $past(wprot)) |-> pslverr);
endmodule

// File: tb/test_ctrl_reg_sync.sv
module test_ctrl_reg_sync;
  localparam int CLK_PERIOD = 10;
  localparam int CCLK_HALF  = 7;
  localparam int AW = 8;

  logic bclk = 0, cclk = 0, brst = 1, crst = 1;
  logic psel = 0, penable = 0, pwrite = 0, wprot = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, cfg_o;
  logic pready, pslverr, master_mode_o;
  logic core_srst_req, core_en, core_en_req;
  logic core_srst_done = 0, core_en_done = 0;
  logic hold_srst = 0;
  int   checks = 0, errors = 0;
  int   srst_cnt = 0, en_cnt = 0;

  always #(CLK_PERIOD/2) bclk = ~bclk;
  always #(CCLK_HALF) cclk = ~cclk;

  ctrl_reg_sync #(.AW(AW)) i_ctrl_reg_sync (
    .bclk(bclk), .brst(brst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .wprot(wprot), .cfg_o(cfg_o), .master_mode_o(master_mode_o),
    .cclk(cclk), .crst(crst), .core_srst_req(core_srst_req),
    .core_srst_done(core_srst_done), .core_en(core_en), .core_en_req(core_en_req),
    .core_en_done(core_en_done)
  );

  // Core-side responder: acknowledge each request after three core cycles.
  always @(posedge cclk) begin
    if (crst) begin
      srst_cnt <= 0; en_cnt <= 0; core_srst_done <= 0; core_en_done <= 0;
    end else begin
      core_srst_done <= 0;
      if (core_srst_req && !core_srst_done && !hold_srst) begin
        if (srst_cnt == 2) begin core_srst_done <= 1; srst_cnt <= 0; end
        else srst_cnt <= srst_cnt + 1;
      end
      core_en_done <= 0;
      if (core_en_req && !core_en_done) begin
        if (en_cnt == 2) begin core_en_done <= 1; en_cnt <= 0; end
        else en_cnt <= en_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d,
                           output logic err);
    @(negedge bclk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge bclk);
    @(negedge bclk);
    penable = 1;
    err = pslverr;
    @(posedge bclk);
    @(negedge bclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge bclk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge bclk);
    @(negedge bclk);
    penable = 1;
    d = prdata;
    @(posedge bclk);
    @(negedge bclk);
    psel = 0; penable = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] b;
    for (int i = 0; i < 200; i++) begin
      apb_read(8'h04, b);
      if (b == 0) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    apb_read(8'h00, d); check(d == 0, "R1 ctrl", d, 0);
    apb_read(8'h04, d); check(d == 0, "R1 busy", d, 0);
    check({cfg_o, master_mode_o, core_en, core_en_req, core_srst_req} == 0,
          "R1 outputs", cfg_o, 0);
    check(pready == 1, "R11 pready", pready, 1);
  endtask

  task automatic t_fields();
    logic [31:0] d; logic e;
    apb_write(8'h00, 32'hFFFF_FFFC, e);
    apb_read(8'h00, d); check(d == 32'h7BF1_009C, "R2 mask", d, 32'h7BF1_009C);
    apb_read(8'h04, d); check(d == 0, "R2 no reset on bit0=0", d, 0);
    check(master_mode_o == 0, "R10 mode 7", master_mode_o, 0);
    apb_write(8'h00, 32'h14, e);
    apb_read(8'h00, d); check(d == 32'h14, "R2 rewrite", d, 32'h14);
    check(master_mode_o == 1, "R10 mode 5", master_mode_o, 1);
    apb_read(8'h08, d); check(d == 0, "R11 unmapped read", d, 0);
    apb_write(8'h08, 32'h80, e); check(e == 0, "R11 unmapped write err", e, 0);
    apb_read(8'h00, d); check(d == 32'h14, "R11 unmapped write no effect", d, 32'h14);
  endtask

  task automatic t_enable();
    logic [31:0] d; logic e;
    apb_write(8'h00, 32'h16, e);
    check(e == 0, "R7 write ok", e, 0);
    apb_read(8'h00, d); check(d == 32'h16, "R7 immediate readback", d, 32'h16);
    apb_read(8'h04, d); check(d == 32'h2, "R7 enable busy", d, 32'h2);
    wait_idle();
    check(core_en == 1, "R7 core enable", core_en, 1);
    check(core_en_req == 0, "R7 request closed", core_en_req, 0);
  endtask

  task automatic t_protect();
    logic [31:0] d; logic e;
    apb_write(8'h00, 32'h7800_0082, e);
    apb_read(8'h00, d); check(d == 32'h16, "R8 protected while enabled", d, 32'h16);
    apb_write(8'h00, 32'h14, e);
    apb_write(8'h00, 32'h16, e);
    apb_read(8'h00, d); check(d == 32'h14, "R8 enable locked while busy", d, 32'h14);
    wait_idle();
    check(core_en == 0, "R8 core disabled", core_en, 0);
  endtask

  task automatic t_wprot();
    logic [31:0] d; logic e;
    wprot = 1;
    apb_write(8'h00, 32'h80, e); check(e == 1, "R9 error", e, 1);
    apb_read(8'h00, d); check(d == 32'h14, "R9 unchanged", d, 32'h14);
    wprot = 0;
  endtask

  task automatic t_swrst();
    logic [31:0] d; logic e;
    hold_srst = 1;
    apb_write(8'h00, 32'hFFFF_FFFF, e);
    check(e == 0, "R3 reset write accepted", e, 0);
    check(cfg_o == 32'h15, "R3 other bits discarded", cfg_o, 32'h15);
    apb_read(8'h00, d); check(d == 0, "R6 reads reset value", d, 0);
    apb_read(8'h04, d); check(d == 32'h1, "R6 busy word live", d, 32'h1);
    for (int i = 0; i < 50 && !core_srst_req; i++) @(posedge cclk);
    check(core_srst_req == 1, "R4 request held", core_srst_req, 1);
    apb_write(8'h00, 32'h80, e); check(e == 1, "R5 write error", e, 1);
    apb_write(8'h08, 32'h80, e); check(e == 1, "R5 any offset", e, 1);
    check(cfg_o == 32'h15, "R5 no change", cfg_o, 32'h15);
    apb_read(8'h04, d); check(d == 32'h1, "R4 still busy before ack", d, 32'h1);
    hold_srst = 0;
    wait_idle();
    check(cfg_o == 0, "R4 fields cleared", cfg_o, 0);
    check(core_srst_req == 0 && core_en == 0, "R4 core side", {core_srst_req, core_en}, 0);
    apb_write(8'h00, 32'h14, e); check(e == 0, "R4 writes accepted again", e, 0);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge cclk);
    @(negedge bclk); brst = 0; crst = 0;
    t_reset();
    t_fields();
    t_enable();
    t_protect();
    t_wprot();
    t_swrst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule